// File: doc/BRIEF.md
# Parallel I/O Port with Direction Override

An eight-pin parallel port of the kind found beside a small microcontroller core. Software programs a per-pin direction register and an output data register over a simple register bus. An external configuration vector can mark pins that a connected load pulls hard enough to act as inputs. Those pins are then read as inputs whatever the direction register holds. The port drives its pin output bus and an output-enable vector from the resulting effective direction.

For handshake-style input, software can enable a latch mode. The first rising edge on the strobe input loads the sampled input pins into the data register and raises a captured flag. Later strobes are dropped until software reads the data register. That read returns the stored value, clears the flag so the next strobe can capture again, and pulses a consumed output for one cycle.

Top module: `gpio_ovr_port`

## Requirements
- R1: After synchronous active-high reset, the direction, data and control registers and the captured flag are all zero, so `pin_oe` and `pin_out` are 0 and every register reads 0 (with `pin_in` at 0).
- R2: The effective direction is `dir & ~ovr_mask` (1 = output). `pin_oe` equals it, and `pin_out` carries the data register only on bits where it is 1, with 0 elsewhere.
- R3: With latch mode off, a data read returns `pin_in` on bits whose effective direction is input and the data register on the output bits.
- R4: When all eight effective direction bits are outputs, a data read returns the data register unchanged, whatever `pin_in` holds.
- R5: The bus addresses are 0 = direction, 1 = data, 2 = control and 3 = unused. Control bit 3 is the read/write latch enable and bit 7 is the read-only captured flag. All other control bits read 0. Address 3 reads 0 and ignores writes.
- R6: With latch mode on and the flag clear, a rising edge on `strobe_in` loads the data register with `pin_in` on the effective-input bits, keeps the register value on the output bits, and sets the captured flag.
- R7: With latch mode on, a data read returns the stored data register rather than the live pins.
- R8: While the captured flag is set, further strobe edges leave the data register unchanged.
- R9: A data-register read clears the captured flag and raises `consumed` for one cycle, together with `bus_rvalid`. Other reads leave `consumed` low.
- R10: A data write stores all eight bits, including bits that are currently inputs or overridden. Those bits appear on `pin_out` once they become effective outputs.
- R11: A strobe edge in the same cycle as a data-register bus access captures nothing and does not set the flag.
- R12: A read issued in cycle t presents `bus_rdata` with `bus_rvalid` high in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| pin_in | input | 8 | External pin levels |
| ovr_mask | input | 8 | Pins forced to input by the external load |
| strobe_in | input | 1 | Capture strobe, rising edge active |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Per-pin output enable |
| consumed | output | 1 | One-cycle pulse on a data-register read |

## Verification
`pin_oe` and `pin_out` are combinational from the registers and `ovr_mask`. A write or a mask change is therefore visible from the clock edge that takes the write, and the bench samples it at the following falling edge. Read data and `consumed` are due exactly one cycle after the read. A scoreboard queue holds the expected value for each issued read, and a monitor pops an entry only when it sees `bus_rvalid` at a falling edge, so any early, late or extra response shows as a mismatch. A strobe capture takes effect at the edge where the rising strobe is first seen. Each capture is therefore followed by a control read for the flag and a data read for the value.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int GPIO_W = 8;

  typedef enum logic [1:0] {
    A_DIR  = 2'd0,
    A_DATA = 2'd1,
    A_CTL  = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  // direction actually in force: override bits always act as inputs
  function automatic logic [GPIO_W-1:0] eff_dir(input logic [GPIO_W-1:0] dir,
                                                input logic [GPIO_W-1:0] mask);
    return dir & ~mask;
  endfunction

  // per bit: pins where eff is input, register where eff is output
  function automatic logic [GPIO_W-1:0] merge_pins(input logic [GPIO_W-1:0] pins,
                                                   input logic [GPIO_W-1:0] regv,
                                                   input logic [GPIO_W-1:0] eff);
    return (pins & ~eff) | (regv & eff);
  endfunction
endpackage

// File: rtl/gpio_strobe_edge.sv
module gpio_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic strobe_evt
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_in;
  end

  assign strobe_evt = strobe_in & ~strobe_q;
endmodule

// File: rtl/gpio_capture_ctl.sv
module gpio_capture_ctl (
  input  logic clk,
  input  logic rst,
  input  logic strobe_evt,
  input  logic latch_en,
  input  logic data_access,
  input  logic data_rd,
  output logic captured,
  output logic capture_fire
);
  assign capture_fire = strobe_evt & latch_en & ~captured & ~data_access;

  always_ff @(posedge clk) begin
    if (rst)               captured <= 1'b0;
    else if (data_rd)      captured <= 1'b0;
    else if (capture_fire) captured <= 1'b1;
  end

  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    capture_fire |=> captured); // R6
  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !captured); // R9
  AST_ACCESS_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (data_access && !captured) |=> !captured); // R11
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         rd_is_data,
  input  logic [W-1:0] rd_value,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         rd_consumed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      rd_consumed <= 1'b0;
    end else begin
      rd_valid    <= rd_en;
      rd_consumed <= rd_en & rd_is_data;
      if (rd_en) rd_data <= rd_value;
    end
  end

  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R12
  AST_CONSUMED_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_consumed |-> rd_valid); // R9
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int LE_BIT  = 3,
  parameter int CAP_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [GPIO_W-1:0] bus_wdata,
  output logic [GPIO_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [GPIO_W-1:0] pin_in,
  input  logic [GPIO_W-1:0] ovr_mask,
  input  logic              strobe_in,
  output logic [GPIO_W-1:0] pin_out,
  output logic [GPIO_W-1:0] pin_oe,
  output logic              consumed
);
  localparam logic [GPIO_W-1:0] CTL_USED = GPIO_W'((1 << LE_BIT) | (1 << CAP_BIT));

  logic [GPIO_W-1:0] dir_q, data_q, eff, rd_value;
  logic              le_q, captured;

  // named bus events
  logic dir_wr, data_wr, data_rd, ctl_wr, any_rd;
  logic strobe_evt, capture_fire;

  assign any_rd  = bus_sel & ~bus_wr;
  assign dir_wr  = bus_sel &  bus_wr & (bus_addr == A_DIR);
  assign data_wr = bus_sel &  bus_wr & (bus_addr == A_DATA);
  assign ctl_wr  = bus_sel &  bus_wr & (bus_addr == A_CTL);
  assign data_rd = any_rd & (bus_addr == A_DATA);

  assign eff = eff_dir(dir_q, ovr_mask);

  gpio_strobe_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (strobe_in),
    .strobe_evt (strobe_evt)
  );

  gpio_capture_ctl u_cap (
    .clk          (clk),
    .rst          (rst),
    .strobe_evt   (strobe_evt),
    .latch_en     (le_q),
    .data_access  (data_wr | data_rd),
    .data_rd      (data_rd),
    .captured     (captured),
    .capture_fire (capture_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      le_q   <= 1'b0;
    end else begin
      if (dir_wr) dir_q <= bus_wdata;
      if (ctl_wr) le_q  <= bus_wdata[LE_BIT];
      if (data_wr)           data_q <= bus_wdata;
      else if (capture_fire) data_q <= merge_pins(pin_in, data_q, eff);
    end
  end

  always_comb begin
    rd_value = '0;
    case (bus_addr)
      A_DIR:  rd_value = dir_q;
      A_DATA: rd_value = (le_q || (&eff)) ? data_q : merge_pins(pin_in, data_q, eff);
      A_CTL: begin
        rd_value[LE_BIT]  = le_q;
        rd_value[CAP_BIT] = captured;
      end
      default: rd_value = '0;
    endcase
  end

  gpio_read_port #(.W(GPIO_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (any_rd),
    .rd_is_data  (data_rd),
    .rd_value    (rd_value),
    .rd_data     (bus_rdata),
    .rd_valid    (bus_rvalid),
    .rd_consumed (consumed)
  );

  assign pin_oe  = eff;
  assign pin_out = data_q & eff;

  AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0); // R2
  AST_OVERRIDE_NEVER_OUT: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ovr_mask) == '0); // R2
  AST_HOLD_WHILE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    (captured && !data_wr) |=> $stable(data_q)); // R8
  AST_CTL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && !consumed && $past(bus_addr) == A_CTL) |-> ((bus_rdata & ~CTL_USED) == '0)); // R5
endmodule

// File: tb/gpio_ovr_port_tb_top.sv
module gpio_ovr_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic       bus_rvalid;
  logic [7:0] pin_in = 8'h00, ovr_mask = 8'h00, pin_out, pin_oe;
  logic       strobe_in = 1'b0, consumed;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] data;
    logic       cons;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  gpio_ovr_port dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_in(pin_in), .ovr_mask(ovr_mask), .strobe_in(strobe_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .consumed(consumed)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rvalid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12 unexpected read data actual=%02h expected=none", bus_rdata);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rdata"}, bus_rdata, e.data);
          check({e.tag, " consumed"}, {7'd0, consumed}, {7'd0, e.cons});
        end
      end else if (consumed) begin
        checks++; errors++;
        $display("FAIL R9 consumed without read actual=1 expected=0");
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.data = exp; e.cons = (a == 2'd1); e.tag = tag;
    sb.push_back(e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic strobe_pulse();
    strobe_in = 1'b1;
    @(posedge clk); @(negedge clk);
    strobe_in = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    bus_read(2'd0, 8'h00, "R1 dir");
    bus_read(2'd1, 8'h00, "R1 data");
    bus_read(2'd2, 8'h00, "R1 ctl");

    // R2/R3 mixed direction
    bus_write(2'd0, 8'hF0);
    bus_write(2'd1, 8'hA5);
    check("R2 pin_oe", pin_oe, 8'hF0);
    check("R2 pin_out", pin_out, 8'hA0);
    pin_in = 8'h3C;
    bus_read(2'd1, (8'h3C & 8'h0F) | (8'hA5 & 8'hF0), "R3 mixed read");

    // R2/R3 with override
    ovr_mask = 8'h30;
    @(negedge clk);
    check("R2 override oe", pin_oe, 8'hC0);
    check("R2 override out", pin_out, 8'h80);
    bus_read(2'd1, (8'h3C & 8'h3F) | (8'hA5 & 8'hC0), "R3 override read");

    // R4 all outputs
    ovr_mask = 8'h00;
    bus_write(2'd0, 8'hFF);
    bus_read(2'd1, 8'hA5, "R4 all out read");

    // R10 write to overridden inputs stored
    ovr_mask = 8'h0F;
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h5A);
    check("R10 hidden out", pin_out, 8'h00);
    ovr_mask = 8'h00;
    bus_write(2'd0, 8'hFF);
    check("R10 revealed out", pin_out, 8'h5A);

    // R5 address map
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, 8'h00, "R5 unused addr");
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, 8'h08, "R5 ctl unused bits");

    // R6 capture
    bus_write(2'd0, 8'hF0);
    ovr_mask = 8'h40;               // eff = B0
    pin_in = 8'hC3;
    strobe_pulse();
    bus_read(2'd2, 8'h88, "R6 flag set");
    check("R6 captured out", pin_out, ((8'hC3 & 8'h4F) | (8'h5A & 8'hB0)) & 8'hB0);

    // R8 second strobe ignored, R7 latched read, R9 clears
    pin_in = 8'h00;
    strobe_pulse();
    bus_read(2'd1, (8'hC3 & 8'h4F) | (8'h5A & 8'hB0), "R7 R8 latched read");
    bus_read(2'd2, 8'h08, "R9 flag cleared");

    // R11 strobe coinciding with data write
    pin_in = 8'hFF;
    strobe_in = 1'b1;
    bus_write(2'd1, 8'h00);
    strobe_in = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_read(2'd2, 8'h08, "R11 no flag");
    bus_read(2'd1, 8'h00, "R11 no capture");

    // R9 re-armed capture
    strobe_pulse();
    bus_read(2'd2, 8'h88, "R9 rearmed flag");
    bus_read(2'd1, 8'h4F, "R9 rearmed data");

    repeat (3) @(negedge clk);
    check("R12 pending reads", 8'(sb.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule